// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block sits between up to six external interrupt pins and the chip's interrupt controller. Each pin first passes through a synchroniser. A detector then watches the pin for the condition picked by a 4-bit trigger code for that channel. The code can select a rising edge, a falling edge, either edge, a high level or a low level. A detected event sets the channel's pending bit. The per-channel output is the pending bit gated by an enable bit, and it leaves the block through a register.

Software configures the block over a simple 32-bit word bus with four registers:

- **Trigger configuration** at offset 0x0.
- **Pin capture** (read-only) at offset 0x4.
- **Pending** at offset 0x8.
- **Enable** at offset 0xC.

To bring a channel up, software follows three steps in order:

1. Write its trigger code.
2. Clear its pending bit.
3. Set its enable bit.

Top module: `extint_unit`

## Requirements
- R1: After reset, all stored configuration, pending and enable bits are zero, every interrupt output is low, and every register reads as zero while the pins are low.
- R2: Each pin passes through two synchronising flops and the output is registered. With the channel enabled in an edge mode, a pin change driven between clock edges shows on the output right after the 4th rising clock edge and not before.
- R3: Channel i's trigger code sits in bits [4i+3:4i] of the configuration register (offset 0x0). Configuration bits above 4×channels are not stored and read back as zero.
- R4: Code 1 latches a pending event on a rising edge and code 2 latches one on a falling edge. Code 3 latches on either edge. In these edge modes the pending bit stays set after the pin returns, until software clears it.
- R5: Code 5 (high level) and code 6 (low level) make the pending bit follow the active level of the synchronised pin. The bit drops when the level goes inactive.
- R6: Codes 0, 4 and 7 to 15 detect nothing: no pin activity sets the pending bit.
- R7: A write to the pending register (offset 0x8) clears every channel whose written bit is 0. Channels whose written bit is 1 keep their state.
- R8: A channel's output is its pending bit ANDed with its enable bit (offset 0xC, bit i). A pending event raised while the channel is disabled stays readable and appears on the output once the channel is enabled.
- R9: Reading offset 0x4 returns the synchronised pin levels in bits [channels-1:0]. Writes to that offset change nothing.
- R10: Read data is registered. It is valid on the clock edge after a read strobe and holds until the next read. Offsets at or above 0x10 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 6 | Asynchronous external interrupt pins |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 6 | Conditioned interrupt output per channel |

## Verification
The hardest state to reach from the ports is a pending bit that is set while its channel is disabled, or one that must outlive the pin activity that caused it. An edge mode keeps the event, but a level mode forgets it once the pin goes quiet. The stimulus reaches this state by pulsing a pin for a few cycles with the enable bit clear. It then reads the pending register before and after enabling the channel.

A table walks channel 0 through every trigger code with chosen start and end pin levels. Each entry reprograms the channel using the clear-then-enable order, so stale pending state from the previous entry cannot leak into the next result.

// File: rtl/eiu_pkg.sv
package eiu_pkg;

  localparam int REG_W = 32;

  // word index of each register (byte offset >> 2)
  localparam logic [1:0] WIX_CFG  = 2'd0;
  localparam logic [1:0] WIX_CAP  = 2'd1;
  localparam logic [1:0] WIX_PEND = 2'd2;
  localparam logic [1:0] WIX_EN   = 2'd3;

  // trigger codes
  localparam logic [3:0] TRIG_OFF  = 4'd0;
  localparam logic [3:0] TRIG_RISE = 4'd1;
  localparam logic [3:0] TRIG_FALL = 4'd2;
  localparam logic [3:0] TRIG_BOTH = 4'd3;
  localparam logic [3:0] TRIG_HIGH = 4'd5;
  localparam logic [3:0] TRIG_LOW  = 4'd6;

  typedef struct packed {
    logic on_rise;
    logic on_fall;
    logic lvl_hi;
    logic lvl_lo;
  } trig_sel_t;

  function automatic trig_sel_t trig_decode(input logic [3:0] code);
    trig_sel_t s;
    s = '0;
    case (code)
      TRIG_RISE: s.on_rise = 1'b1;
      TRIG_FALL: s.on_fall = 1'b1;
      TRIG_BOTH: begin
        s.on_rise = 1'b1;
        s.on_fall = 1'b1;
      end
      TRIG_HIGH: s.lvl_hi = 1'b1;
      TRIG_LOW:  s.lvl_lo = 1'b1;
      default:   s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/eiu_sync.sv
module eiu_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/eiu_chan.sv
module eiu_chan
  import eiu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl_i,
  input  logic [3:0] code_i,
  input  logic       keep_i,
  output logic       pend_o
);

  logic      prev_q;
  logic      pend_q;
  logic      pend_d;
  trig_sel_t sel;
  logic      rise, fall, is_lvl, hit_edge, lvl_act;

  always_comb begin
    sel      = trig_decode(code_i);
    rise     = lvl_i & ~prev_q;
    fall     = ~lvl_i & prev_q;
    is_lvl   = sel.lvl_hi | sel.lvl_lo;
    hit_edge = (sel.on_rise & rise) | (sel.on_fall & fall);
    lvl_act  = (sel.lvl_hi & lvl_i) | (sel.lvl_lo & ~lvl_i);
    if (is_lvl) pend_d = lvl_act;
    else        pend_d = (pend_q & keep_i) | hit_edge;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (sel == '0 && !pend_q) |=> !pend_q); // R6

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((sel.on_rise || sel.on_fall) && pend_q && keep_i) |=> pend_q); // R4

  AST_EDGE_CATCH: assert property (@(posedge clk) disable iff (rst)
    (sel.on_rise && lvl_i && !prev_q) |=> pend_q); // R4

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
    (sel.lvl_hi && !lvl_i) |=> !pend_q); // R5

endmodule

// File: rtl/eiu_regs.sv
module eiu_regs
  import eiu_pkg::*;
#(
  parameter int N_CH   = 6,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [N_CH-1:0]   lvl_i,
  input  logic [N_CH-1:0]   pend_i,
  output logic [4*N_CH-1:0] cfg_o,
  output logic [N_CH-1:0]   keep_o,
  output logic [N_CH-1:0]   en_o
);

  localparam int CFG_W = 4 * N_CH;

  logic [CFG_W-1:0] cfg_q;
  logic [N_CH-1:0]  en_q;
  logic [REG_W-1:0] rdata_q;
  logic [REG_W-1:0] rmux;
  logic [1:0]       widx;
  logic             in_range;

  assign widx     = addr_i[3:2];
  assign in_range = (addr_i >> 4) == '0;

  always_comb begin
    keep_o = '1;
    if (wr_i && in_range && widx == WIX_PEND) keep_o = wdata_i[N_CH-1:0];
  end

  always_comb begin
    rmux = '0;
    if (in_range) begin
      case (widx)
        WIX_CFG:  rmux = REG_W'(cfg_q);
        WIX_CAP:  rmux = REG_W'(lvl_i);
        WIX_PEND: rmux = REG_W'(pend_i);
        default:  rmux = REG_W'(en_q);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      en_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_i && in_range && widx == WIX_CFG) cfg_q <= wdata_i[CFG_W-1:0];
      if (wr_i && in_range && widx == WIX_EN)  en_q  <= wdata_i[N_CH-1:0];
      if (rd_i) rdata_q <= rmux;
    end
  end

  assign cfg_o   = cfg_q;
  assign en_o    = en_q;
  assign rdata_o = rdata_q;

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(cfg_q)); // R3

  AST_EN_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(en_q)); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_q)); // R10

endmodule

// File: rtl/extint_unit.sv
module extint_unit
  import eiu_pkg::*;
#(
  parameter int N_CH        = 6,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CH-1:0]   pin_i,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [N_CH-1:0]   irq_o
);

  logic [N_CH-1:0]   lvl;
  logic [N_CH-1:0]   pend;
  logic [N_CH-1:0]   keep;
  logic [N_CH-1:0]   en;
  logic [4*N_CH-1:0] cfg;
  logic [N_CH-1:0]   irq_q;

  eiu_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (lvl)
  );

  eiu_regs #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (bus_wr),
    .rd_i    (bus_rd),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .rdata_o (bus_rdata),
    .lvl_i   (lvl),
    .pend_i  (pend),
    .cfg_o   (cfg),
    .keep_o  (keep),
    .en_o    (en)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    eiu_chan u_chan (
      .clk    (clk),
      .rst    (rst),
      .lvl_i  (lvl[i]),
      .code_i (cfg[4*i +: 4]),
      .keep_i (keep[i]),
      .pend_o (pend[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= pend & en;
  end

  assign irq_o = irq_q;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    (irq_q & ~$past(en)) == '0); // R8

  AST_IRQ_FROM_PEND: assert property (@(posedge clk) disable iff (rst)
    (irq_q & ~$past(pend)) == '0); // R8

endmodule

// File: tb/tb_extint_unit.sv
module tb_extint_unit;

  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] pin = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq;

  int total = 0;
  int bad = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  extint_unit dut (
    .clk       (clk),
    .rst       (rst),
    .pin_i     (pin),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq)
  );

  // {code[3:0], start level, end level, expected irq[0]}
  localparam int NV = 16;
  localparam logic [6:0] VEC [NV] = '{
    {4'd0,  1'b0, 1'b1, 1'b0},
    {4'd1,  1'b0, 1'b1, 1'b1},
    {4'd1,  1'b1, 1'b0, 1'b0},
    {4'd2,  1'b1, 1'b0, 1'b1},
    {4'd2,  1'b0, 1'b1, 1'b0},
    {4'd3,  1'b0, 1'b1, 1'b1},
    {4'd3,  1'b1, 1'b0, 1'b1},
    {4'd5,  1'b0, 1'b1, 1'b1},
    {4'd5,  1'b1, 1'b0, 1'b0},
    {4'd6,  1'b1, 1'b0, 1'b1},
    {4'd6,  1'b0, 1'b1, 1'b0},
    {4'd4,  1'b0, 1'b1, 1'b0},
    {4'd7,  1'b1, 1'b0, 1'b0},
    {4'd15, 1'b0, 1'b1, 1'b0},
    {4'd9,  1'b1, 1'b0, 1'b0},
    {4'd1,  1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    wait_n(4);
    rst = 1'b0;
    wait_n(1);

    // R1 reset state
    check("R1 irq", 32'(irq), 32'h0);
    rd(8'h00, rv); check("R1 cfg", rv, 32'h0);
    rd(8'h04, rv); check("R1 cap", rv, 32'h0);
    rd(8'h08, rv); check("R1 pend", rv, 32'h0);
    rd(8'h0C, rv); check("R1 en", rv, 32'h0);

    // table walk on channel 0: R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      pin[0] = VEC[v][2];
      wait_n(4);
      wr(8'h00, {28'h0, VEC[v][6:3]});
      wr(8'h08, 32'h0);
      wr(8'h0C, 32'h1);
      pin[0] = VEC[v][1];
      wait_n(5);
      check($sformatf("R4/R5/R6 vec%0d code=%0d", v, VEC[v][6:3]),
            32'(irq[0]), 32'(VEC[v][0]));
    end
    pin = '0;
    wr(8'h0C, 32'h0);
    wr(8'h00, 32'h0);
    wait_n(4);
    wr(8'h08, 32'h0);

    // R2 latency: rising mode, enabled
    wr(8'h00, 32'h1);
    wr(8'h0C, 32'h1);
    wait_n(2);
    @(negedge clk); pin[0] = 1'b1;
    wait_n(3);
    check("R2 before 4th edge", 32'(irq[0]), 32'h0);
    wait_n(1);
    check("R2 at 4th edge", 32'(irq[0]), 32'h1);

    // R4 edge latched after pin returns
    pin[0] = 1'b0;
    wait_n(6);
    check("R4 held after pin drop", 32'(irq[0]), 32'h1);

    // R7 clear writes 0 clears, 1 keeps
    wr(8'h00, 32'h0000_0011);          // ch0, ch1 rising
    wr(8'h0C, 32'h3);
    pin[1] = 1'b1;
    wait_n(5);
    check("R7 setup both pending", 32'(irq[1:0]), 32'h3);
    wr(8'h08, 32'h0000_0002);          // clear ch0 only
    wait_n(1);
    check("R7 selective clear", 32'(irq[1:0]), 32'h2);
    rd(8'h08, rv); check("R7 pend readback", rv, 32'h2);
    wr(8'h08, 32'h0);
    wait_n(1);
    check("R7 clear all", 32'(irq[1:0]), 32'h0);
    pin[1] = 1'b0;
    wait_n(4);

    // R8 pending while disabled
    wr(8'h0C, 32'h0);
    wr(8'h00, 32'h0000_0002);          // ch0 falling
    wr(8'h08, 32'h0);
    pin[0] = 1'b1; wait_n(4);
    pin[0] = 1'b0; wait_n(2);
    pin[0] = 1'b1; wait_n(5);
    check("R8 disabled output low", 32'(irq[0]), 32'h0);
    rd(8'h08, rv); check("R8 pending kept", rv & 32'h1, 32'h1);
    wr(8'h0C, 32'h1);
    wait_n(1);
    check("R8 appears on enable", 32'(irq[0]), 32'h1);
    wr(8'h0C, 32'h0);
    wait_n(1);
    check("R8 disable blocks", 32'(irq[0]), 32'h0);
    pin[0] = 1'b0;
    wait_n(4);
    wr(8'h08, 32'h0);

    // R5 level pulse not latched
    wr(8'h00, 32'h0000_0005);
    wr(8'h0C, 32'h1);
    pin[0] = 1'b1; wait_n(5);
    check("R5 high active", 32'(irq[0]), 32'h1);
    pin[0] = 1'b0; wait_n(5);
    check("R5 level released", 32'(irq[0]), 32'h0);

    // R3 field positions: ch3 rising at [15:12], ch5 falling at [23:20]
    wr(8'h0C, 32'h0);
    pin[5] = 1'b1;
    wait_n(4);
    wr(8'h00, 32'hFF20_1000);
    rd(8'h00, rv); check("R3 readback upper bits dropped", rv, 32'h0020_1000);
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'h3F);
    pin[3] = 1'b1; pin[5] = 1'b0;
    wait_n(5);
    check("R3 ch3 and ch5 only", 32'(irq), 32'h28);

    // R9 capture reflects pins, writes ignored
    pin = 6'b10_0110;
    wait_n(3);
    rd(8'h04, rv); check("R9 capture", rv, 32'h26);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, rv); check("R9 write ignored", rv, 32'h26);

    // R10 unmapped reads zero, hold without strobe
    rd(8'h10, rv); check("R10 unmapped", rv, 32'h0);
    rd(8'h00, rv);
    wait_n(3);
    check("R10 hold", bus_rdata, 32'h0020_1000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule